// File: doc/BRIEF.md
# Packet Header Protocol Executor

This block sits on the receive side of one link channel, between the link layer's token decoder and the channel's receive FIFO. Each packet begins with a four-byte header. The first packet after reset starts with one, and so does every packet that follows an end marker. The block captures the header, checks the destination address and the command, and then does one of two things. It can pass the packet's payload into the FIFO, or it can carry out a control command. The commands drive a CPU reset line, four external signal lines, a pulse that resets this link and a pulse that resets all links. Every header byte is also copied to an acknowledge queue, so a later stage can build an automatic acknowledge.

Commands that can disturb the system are safety critical. These are CPU reset on or off, link reset and all-links reset. They run only if an arming command arrived earlier. One safety-critical command then consumes the arming. When the channel is in transparent or routing mode, the `bypass` input is high. The executor then stands aside and every token goes to the FIFO unchanged.

The header bytes arrive in this order: address, command, transaction ID, control. The command byte uses these codes:

- 0x01: data
- 0x10: arm
- 0x20: CPU reset on
- 0x21: CPU reset off
- 0x3n: external signal n on, for n from 0 to 3
- 0x4n: external signal n off, for n from 0 to 3
- 0x50: reset this link
- 0x51: reset all links

Every other code is invalid. The FSM has four states:

- ST_HDR collects header bytes.
- ST_PAYLOAD forwards data.
- ST_DISCARD drops the rest of a packet.
- ST_BYPASS is held while `bypass` is high.

The transitions are as follows:

- ST_HDR goes to ST_PAYLOAD after a fourth byte that carries a matching address and the data command.
- ST_HDR goes to ST_DISCARD after any other fourth byte.
- ST_HDR stays in ST_HDR on an end marker.
- ST_PAYLOAD returns to ST_HDR on an end marker.
- ST_DISCARD returns to ST_HDR on an end marker.
- Any state goes to ST_BYPASS while `bypass` is high.
- ST_BYPASS goes back to ST_HDR once `bypass` is low.

Top module: `pkt_hdr_exec`

## Requirements
- R1: After reset every output is 0, and the next data token is taken as header byte 0, the address.
- R2: Each header byte gives one `ack_wr` pulse in the cycle after its token, with `ack_data` equal to the byte. Payload bytes and end markers give no `ack_wr`.
- R3: Take a header whose address equals `chan_addr` and whose command is 0x01. Each following data token and the closing end marker is written to the FIFO one cycle later. The end marker appears with `fifo_eop`=1 and data tokens with `fifo_eop`=0.
- R4: If the address byte differs from `chan_addr`, `hdr_err` pulses for one cycle after the fourth header byte. No command runs and the payload is dropped.
- R5: A command code outside the list in this brief raises the same `hdr_err` pulse, and the payload is dropped. This includes 0x34 to 0x3F and 0x44 to 0x4F.
- R6: Command 0x3n sets `ext_sig[n]` and 0x4n clears it, in the cycle after the fourth header byte. No arming is needed.
- R7: A safety-critical command (0x20, 0x21, 0x50, 0x51) that arrives while the block is not armed raises `hdr_err` and leaves all outputs unchanged.
- R8: Command 0x10 arms the block. The next safety-critical command then runs: 0x20 sets `cpu_reset` and 0x21 clears it. That command disarms the block, so a second safety-critical command is refused. An arm packet with a mismatched address does not arm the block.
- R9: Once armed, 0x50 gives a one-cycle `link_rst` pulse and 0x51 gives a one-cycle `all_rst` pulse.
- R10: An end marker after one to three header bytes gives a one-cycle `short_err` pulse and writes nothing to the FIFO. An end marker with no header bytes gives no error. In both cases the next data token starts a new header.
- R11: `tid_q` takes header byte 2 and `ctl_q` takes header byte 3 of each header, whether or not the header is accepted.
- R12: While `bypass` is 1, every token is written to the FIFO one cycle later, with end markers flagged by `fifo_eop`. No acknowledge is sent, no command runs and the arming state is unchanged. After `bypass` drops, the next data token is header byte 0.
- R13: The payload of any packet whose command is not 0x01 is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bypass | input | 1 | Transparent or routing mode: pass every token straight to the FIFO |
| chan_addr | input | 8 | Address of this channel |
| tok_valid | input | 1 | A token is present this cycle |
| tok_eop | input | 1 | The token is an end marker (either kind) |
| tok_data | input | 8 | Data byte of the token |
| fifo_wr | output | 1 | Write strobe to the receive FIFO |
| fifo_data | output | 8 | Byte written to the FIFO |
| fifo_eop | output | 1 | The FIFO write is an end marker |
| ack_wr | output | 1 | Write strobe to the acknowledge queue |
| ack_data | output | 8 | Header byte for the acknowledge queue |
| hdr_err | output | 1 | Header error: address mismatch, invalid command or refused safety command |
| short_err | output | 1 | Packet ended inside its header |
| cpu_reset | output | 1 | CPU reset line |
| ext_sig | output | 4 | External signal lines |
| link_rst | output | 1 | One-cycle reset of this link |
| all_rst | output | 1 | One-cycle reset of all links |
| tid_q | output | 8 | Last transaction ID byte |
| ctl_q | output | 8 | Last control byte |

## Verification
Every result of this block is registered once. A token sampled at one rising edge shows up on the outputs just after that same edge.

- FIFO and acknowledge writes follow their own token by one cycle.
- Errors and command outputs follow the fourth header byte by one cycle.
- `short_err` follows the end marker by one cycle.

The bench drives each token just after a rising edge and samples the outputs one clock later, just after the next rising edge. It adds up each strobe over a whole packet and compares the totals and the final output levels with a reference model. A sweep runs all 256 command codes through that model, with the arming state carried from packet to packet.

// File: rtl/phe_pkg.sv
package phe_pkg;

    typedef enum logic [1:0] {
        ST_HDR,
        ST_PAYLOAD,
        ST_DISCARD,
        ST_BYPASS
    } phe_state_t;

    typedef enum logic [3:0] {
        K_DATA,
        K_ARM,
        K_CPU_ON,
        K_CPU_OFF,
        K_SIG_ON,
        K_SIG_OFF,
        K_LINK_RST,
        K_ALL_RST,
        K_BAD
    } cmd_kind_t;

    function automatic cmd_kind_t decode_cmd(input logic [7:0] c, input int nsig);
        cmd_kind_t k;
        k = K_BAD;
        if (c == 8'h01)      k = K_DATA;
        else if (c == 8'h10) k = K_ARM;
        else if (c == 8'h20) k = K_CPU_ON;
        else if (c == 8'h21) k = K_CPU_OFF;
        else if (c == 8'h50) k = K_LINK_RST;
        else if (c == 8'h51) k = K_ALL_RST;
        else if (c[7:4] == 4'h3 && int'(c[3:0]) < nsig) k = K_SIG_ON;
        else if (c[7:4] == 4'h4 && int'(c[3:0]) < nsig) k = K_SIG_OFF;
        return k;
    endfunction

endpackage

// File: rtl/phe_hdr_regs.sv
module phe_hdr_regs #(
    parameter int DW      = 8,
    parameter int HDR_LEN = 4,
    localparam int CW     = $clog2(HDR_LEN)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [CW-1:0]                wr_idx,
    input  logic [DW-1:0]                wr_byte,
    output logic [HDR_LEN-1:0][DW-1:0]   hdr_q
);
    for (genvar i = 0; i < HDR_LEN; i++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                hdr_q[i] <= '0;
            else if (wr_en && wr_idx == CW'(i))
                hdr_q[i] <= wr_byte;
        end
    end
endmodule

// File: rtl/phe_fsm.sv
module phe_fsm
    import phe_pkg::*;
#(
    parameter int DW      = 8,
    parameter int HDR_LEN = 4,
    parameter int NSIG    = 4,
    localparam int CW     = $clog2(HDR_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bypass,
    input  logic [DW-1:0] chan_addr,
    input  logic          tok_valid,
    input  logic          tok_eop,
    input  logic [DW-1:0] tok_data,
    input  logic [DW-1:0] addr_q,
    input  logic [DW-1:0] cmd_q,
    output logic          hdr_we,
    output logic [CW-1:0] hdr_idx,
    output logic          exec_req,
    output logic          fifo_wr,
    output logic [DW-1:0] fifo_data,
    output logic          fifo_eop,
    output logic          ack_wr,
    output logic [DW-1:0] ack_data,
    output logic          hdr_err,
    output logic          short_err
);
    localparam logic [CW-1:0] LAST = CW'(HDR_LEN - 1);

    phe_state_t st, st_n;
    logic [CW-1:0] cnt, cnt_n;
    logic fwr_n, feop_n, awr_n, err_n, serr_n;
    cmd_kind_t kind;

    assign kind    = decode_cmd(cmd_q, NSIG);
    assign hdr_idx = cnt;

    always_comb begin
        st_n     = st;
        cnt_n    = cnt;
        fwr_n    = 1'b0;
        feop_n   = 1'b0;
        awr_n    = 1'b0;
        err_n    = 1'b0;
        serr_n   = 1'b0;
        hdr_we   = 1'b0;
        exec_req = 1'b0;
        if (bypass) begin
            st_n  = ST_BYPASS;
            cnt_n = '0;
            if (tok_valid) begin
                fwr_n  = 1'b1;
                feop_n = tok_eop;
            end
        end else if (tok_valid) begin
            unique case (st)
                ST_HDR, ST_BYPASS: begin
                    st_n = ST_HDR;
                    if (tok_eop) begin
                        serr_n = (cnt != '0);
                        cnt_n  = '0;
                    end else begin
                        awr_n  = 1'b1;
                        hdr_we = 1'b1;
                        if (cnt == LAST) begin
                            cnt_n = '0;
                            st_n  = ST_DISCARD;
                            if (addr_q != chan_addr)  err_n = 1'b1;
                            else if (kind == K_DATA)  st_n = ST_PAYLOAD;
                            else if (kind == K_BAD)   err_n = 1'b1;
                            else                      exec_req = 1'b1;
                        end else begin
                            cnt_n = cnt + CW'(1);
                        end
                    end
                end
                ST_PAYLOAD: begin
                    fwr_n  = 1'b1;
                    feop_n = tok_eop;
                    if (tok_eop) st_n = ST_HDR;
                end
                ST_DISCARD: begin
                    if (tok_eop) st_n = ST_HDR;
                end
            endcase
        end else if (st == ST_BYPASS) begin
            st_n = ST_HDR;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_HDR;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fifo_wr   <= 1'b0;
            fifo_eop  <= 1'b0;
            fifo_data <= '0;
            ack_wr    <= 1'b0;
            ack_data  <= '0;
            hdr_err   <= 1'b0;
            short_err <= 1'b0;
        end else begin
            fifo_wr   <= fwr_n;
            fifo_eop  <= feop_n;
            ack_wr    <= awr_n;
            hdr_err   <= err_n;
            short_err <= serr_n;
            if (fwr_n) fifo_data <= tok_data;
            if (awr_n) ack_data  <= tok_data;
        end
    end
endmodule

// File: rtl/phe_cmd_exec.sv
module phe_cmd_exec
    import phe_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NSIG = 4,
    localparam int SW  = (NSIG > 1) ? $clog2(NSIG) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic [DW-1:0]   cmd,
    output logic            cpu_reset,
    output logic [NSIG-1:0] ext_sig,
    output logic            link_rst,
    output logic            all_rst,
    output logic            deny
);
    cmd_kind_t kind;
    logic armed;
    logic [SW-1:0] sidx;

    assign kind = decode_cmd(cmd, NSIG);
    assign sidx = cmd[SW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed     <= 1'b0;
            cpu_reset <= 1'b0;
            ext_sig   <= '0;
            link_rst  <= 1'b0;
            all_rst   <= 1'b0;
            deny      <= 1'b0;
        end else begin
            link_rst <= 1'b0;
            all_rst  <= 1'b0;
            deny     <= 1'b0;
            if (req) begin
                case (kind)
                    K_ARM:     armed <= 1'b1;
                    K_SIG_ON:  ext_sig[sidx] <= 1'b1;
                    K_SIG_OFF: ext_sig[sidx] <= 1'b0;
                    K_CPU_ON, K_CPU_OFF, K_LINK_RST, K_ALL_RST: begin
                        if (armed) begin
                            armed <= 1'b0;
                            if (kind == K_CPU_ON)   cpu_reset <= 1'b1;
                            if (kind == K_CPU_OFF)  cpu_reset <= 1'b0;
                            if (kind == K_LINK_RST) link_rst  <= 1'b1;
                            if (kind == K_ALL_RST)  all_rst   <= 1'b1;
                        end else begin
                            deny <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/pkt_hdr_exec.sv
module pkt_hdr_exec #(
    parameter int DW      = 8,
    parameter int HDR_LEN = 4,
    parameter int NSIG    = 4,
    localparam int CW     = $clog2(HDR_LEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bypass,
    input  logic [DW-1:0]   chan_addr,
    input  logic            tok_valid,
    input  logic            tok_eop,
    input  logic [DW-1:0]   tok_data,
    output logic            fifo_wr,
    output logic [DW-1:0]   fifo_data,
    output logic            fifo_eop,
    output logic            ack_wr,
    output logic [DW-1:0]   ack_data,
    output logic            hdr_err,
    output logic            short_err,
    output logic            cpu_reset,
    output logic [NSIG-1:0] ext_sig,
    output logic            link_rst,
    output logic            all_rst,
    output logic [DW-1:0]   tid_q,
    output logic [DW-1:0]   ctl_q
);
    logic [HDR_LEN-1:0][DW-1:0] hdr_q;
    logic hdr_we, exec_req, fsm_err, deny;
    logic [CW-1:0] hdr_idx;

    phe_hdr_regs #(.DW(DW), .HDR_LEN(HDR_LEN)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(hdr_we), .wr_idx(hdr_idx),
        .wr_byte(tok_data), .hdr_q(hdr_q)
    );

    phe_fsm #(.DW(DW), .HDR_LEN(HDR_LEN), .NSIG(NSIG)) u_fsm (
        .clk(clk), .rst_n(rst_n), .bypass(bypass), .chan_addr(chan_addr),
        .tok_valid(tok_valid), .tok_eop(tok_eop), .tok_data(tok_data),
        .addr_q(hdr_q[0]), .cmd_q(hdr_q[1]),
        .hdr_we(hdr_we), .hdr_idx(hdr_idx), .exec_req(exec_req),
        .fifo_wr(fifo_wr), .fifo_data(fifo_data), .fifo_eop(fifo_eop),
        .ack_wr(ack_wr), .ack_data(ack_data),
        .hdr_err(fsm_err), .short_err(short_err)
    );

    phe_cmd_exec #(.DW(DW), .NSIG(NSIG)) u_exec (
        .clk(clk), .rst_n(rst_n), .req(exec_req), .cmd(hdr_q[1]),
        .cpu_reset(cpu_reset), .ext_sig(ext_sig),
        .link_rst(link_rst), .all_rst(all_rst), .deny(deny)
    );

    assign hdr_err = fsm_err | deny;
    assign tid_q   = hdr_q[2];
    assign ctl_q   = hdr_q[3];
endmodule

// File: rtl/phe_chk.sv
module phe_chk #(
    parameter int DW   = 8,
    parameter int NSIG = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            fifo_wr,
    input logic            ack_wr,
    input logic            hdr_err,
    input logic            short_err,
    input logic            cpu_reset,
    input logic [NSIG-1:0] ext_sig,
    input logic            link_rst,
    input logic            all_rst
);
    // R9
    link_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_rst |=> !link_rst);

    // R9
    reset_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({link_rst, all_rst, hdr_err}));

    // R6
    sig_on_header_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ext_sig) |-> ack_wr);

    // R8
    cpu_on_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cpu_reset) |-> (ack_wr && !hdr_err));

    // R4
    err_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_err |-> !fifo_wr);

    // R10
    short_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        short_err |-> (!ack_wr && !fifo_wr && !hdr_err));

    // R2
    ack_fifo_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_wr && fifo_wr));
endmodule

bind pkt_hdr_exec phe_chk #(.DW(DW), .NSIG(NSIG)) u_phe_chk (.*);

// File: tb/pkt_hdr_exec_test.sv
module pkt_hdr_exec_test;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 100000;
    localparam logic [7:0] CH = 8'h5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bypass = 1'b0;
    logic tok_valid = 1'b0, tok_eop = 1'b0;
    logic [7:0] tok_data = '0;
    logic fifo_wr, fifo_eop, ack_wr, hdr_err, short_err, cpu_reset, link_rst, all_rst;
    logic [7:0] fifo_data, ack_data, tid_q, ctl_q;
    logic [3:0] ext_sig;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_hdr_exec uut (
        .clk(clk), .rst_n(rst_n), .bypass(bypass), .chan_addr(CH),
        .tok_valid(tok_valid), .tok_eop(tok_eop), .tok_data(tok_data),
        .fifo_wr(fifo_wr), .fifo_data(fifo_data), .fifo_eop(fifo_eop),
        .ack_wr(ack_wr), .ack_data(ack_data), .hdr_err(hdr_err),
        .short_err(short_err), .cpu_reset(cpu_reset), .ext_sig(ext_sig),
        .link_rst(link_rst), .all_rst(all_rst), .tid_q(tid_q), .ctl_q(ctl_q)
    );

    int vectors = 0, fails = 0;
    int fifo_cnt, eop_cnt, fsum, ack_cnt, ack_bad, err_cnt, short_cnt, lr_cnt, ar_cnt;
    bit m_armed = 0, m_cpu = 0;
    logic [3:0] m_sig = '0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clr();
        fifo_cnt = 0; eop_cnt = 0; fsum = 0; ack_cnt = 0; ack_bad = 0;
        err_cnt = 0; short_cnt = 0; lr_cnt = 0; ar_cnt = 0;
    endtask

    task automatic step(input bit v, input bit e, input logic [7:0] d);
        tok_valid = v; tok_eop = e; tok_data = d;
        @(posedge clk); #1;
        if (fifo_wr) begin
            fifo_cnt++;
            if (fifo_eop) eop_cnt++; else fsum += int'(fifo_data);
        end
        if (ack_wr) begin
            ack_cnt++;
            if (ack_data !== d) ack_bad++;
        end
        if (hdr_err)   err_cnt++;
        if (short_err) short_cnt++;
        if (link_rst)  lr_cnt++;
        if (all_rst)   ar_cnt++;
        tok_valid = 1'b0; tok_eop = 1'b0;
    endtask

    // 0 data,1 arm,2 cpu on,3 cpu off,4 sig on,5 sig off,6 link rst,7 all rst,8 invalid
    function automatic int kind_of(input logic [7:0] c);
        if (c == 8'h01) return 0;
        if (c == 8'h10) return 1;
        if (c == 8'h20) return 2;
        if (c == 8'h21) return 3;
        if (c == 8'h50) return 6;
        if (c == 8'h51) return 7;
        if (c[7:4] == 4'h3 && c[3:0] < 4) return 4;
        if (c[7:4] == 4'h4 && c[3:0] < 4) return 5;
        return 8;
    endfunction

    task automatic pkt(input logic [7:0] a, input logic [7:0] c, input int npay);
        logic [7:0] tid, ctl;
        int k, exp_err, exp_fifo, exp_sum, exp_lr, exp_ar;
        bit safety;
        string etag;
        tid = c ^ 8'h3C; ctl = a + c;
        k = kind_of(c);
        safety = (k == 2 || k == 3 || k == 6 || k == 7);
        exp_err = 0; exp_fifo = 0; exp_sum = 0; exp_lr = 0; exp_ar = 0;
        if (a != CH) begin
            exp_err = 1; etag = "R4";
        end else if (k == 8) begin
            exp_err = 1; etag = "R5";
        end else begin
            etag = safety ? "R7" : "R8";
            if (k == 0) begin
                exp_fifo = npay + 1;
                for (int i = 0; i < npay; i++) exp_sum += 8'hC0 + i;
            end else if (k == 1) m_armed = 1;
            else if (k == 4) m_sig[c[1:0]] = 1'b1;
            else if (k == 5) m_sig[c[1:0]] = 1'b0;
            else if (safety) begin
                if (!m_armed) exp_err = 1;
                else begin
                    m_armed = 0;
                    if (k == 2) m_cpu = 1;
                    if (k == 3) m_cpu = 0;
                    if (k == 6) exp_lr = 1;
                    if (k == 7) exp_ar = 1;
                end
            end
        end
        clr();
        step(1, 0, a); step(1, 0, c); step(1, 0, tid); step(1, 0, ctl);
        for (int i = 0; i < npay; i++) step(1, 0, 8'(8'hC0 + i));
        step(1, 1, 8'h00);
        step(0, 0, 8'h00);
        chk(ack_cnt == 4 && ack_bad == 0, "R2 ack count", ack_cnt, 4);
        chk(err_cnt == exp_err, etag, err_cnt, exp_err);
        chk(fifo_cnt == exp_fifo, (k == 0) ? "R3 fifo writes" : "R13 discard", fifo_cnt, exp_fifo);
        chk(fsum == exp_sum && eop_cnt == (exp_fifo > 0 ? 1 : 0), "R3 payload", fsum, exp_sum);
        chk(ext_sig == m_sig, "R6 ext_sig", int'(ext_sig), int'(m_sig));
        chk(cpu_reset == m_cpu, "R8 cpu_reset", int'(cpu_reset), int'(m_cpu));
        chk(lr_cnt == exp_lr && ar_cnt == exp_ar, "R9 reset pulses", lr_cnt * 2 + ar_cnt, exp_lr * 2 + exp_ar);
        chk(tid_q == tid && ctl_q == ctl, "R11 tid/ctl", {tid_q, ctl_q}, {tid, ctl});
    endtask

    task automatic short_hdr(input int n);
        clr();
        for (int i = 0; i < n; i++) step(1, 0, 8'(CH + i));
        step(1, 1, 8'h00);
        step(0, 0, 8'h00);
        chk(short_cnt == (n != 0 ? 1 : 0), "R10 short_err", short_cnt, n != 0 ? 1 : 0);
        chk(fifo_cnt == 0 && ack_cnt == n, "R10 nothing forwarded", fifo_cnt, 0);
        pkt(CH, 8'h01, 1);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 reset state
        chk({fifo_wr, ack_wr, hdr_err, short_err, cpu_reset, ext_sig, link_rst, all_rst} == '0,
            "R1 reset outputs", int'({cpu_reset, ext_sig}), 0);
        chk(tid_q == 8'h00 && ctl_q == 8'h00, "R1 header regs", {tid_q, ctl_q}, 0);
        pkt(CH, 8'h01, 3);   // R1: first packet after reset carries a header

        // full command sweep, arming state carried across packets
        for (int c = 0; c < 256; c++) pkt(CH, 8'(c), 2);

        // directed arming sequences (R8, R9)
        pkt(CH, 8'h10, 0); pkt(CH, 8'h21, 1);
        pkt(CH, 8'h20, 0);
        pkt(CH, 8'h10, 0); pkt(CH, 8'h20, 0); pkt(CH, 8'h20, 0);
        pkt(CH, 8'h10, 0); pkt(CH, 8'h50, 2); pkt(CH, 8'h50, 0);
        pkt(CH, 8'h10, 0); pkt(CH, 8'h51, 0);
        pkt(CH, 8'h10, 0); pkt(8'h11, 8'h21, 0); pkt(CH, 8'h21, 0);
        pkt(8'h11, 8'h10, 0); pkt(CH, 8'h50, 0);

        // address sweep with data command (R4)
        for (int a = 0; a < 256; a += 15) pkt(8'(a), 8'h01, 2);

        // short headers (R10)
        for (int n = 0; n < 4; n++) short_hdr(n);

        // bypass (R12)
        bypass = 1'b1;
        step(0, 0, 8'h00);
        clr();
        step(1, 0, CH); step(1, 0, 8'h32); step(1, 0, 8'h01); step(1, 0, 8'h02);
        step(1, 0, 8'h77); step(1, 1, 8'h00);
        step(1, 0, CH); step(1, 0, 8'h10); step(1, 0, 8'h00); step(1, 0, 8'h00); step(1, 1, 8'h00);
        step(0, 0, 8'h00);
        chk(fifo_cnt == 11 && eop_cnt == 2, "R12 all tokens forwarded", fifo_cnt, 11);
        chk(fsum == int'(CH) * 2 + 8'h32 + 8'h10 + 1 + 2 + 8'h77, "R12 data unchanged", fsum,
            int'(CH) * 2 + 8'h32 + 8'h10 + 1 + 2 + 8'h77);
        chk(ack_cnt == 0 && err_cnt == 0, "R12 no ack", ack_cnt, 0);
        chk(ext_sig == m_sig, "R12 no command", int'(ext_sig), int'(m_sig));
        bypass = 1'b0;
        pkt(CH, 8'h20, 0);   // R12: arm inside bypass had no effect
        pkt(CH, 8'h01, 2);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule